// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse macro and keeps them in a 32-byte shadow register file. A single start pulse, together with a start address, a byte count and a sequencing mode, launches the read. The sequencer then drives one control word into the macro, holding every step for a programmable number of clock cycles. It samples the macro's data byte once on each strobe and writes that byte into the shadow file at the byte's own fuse address.

Several fields are decoded from the shadow file and held on outputs at all times: a version byte, a process nibble, a revision pair, a leakage byte chosen by a channel select, and a signed temperature trim. Two macro variants are handled. In mode 0 the macro is opened with a chip-select handshake. Mode 1 uses only the load line and has the address field at another bit offset. One time unit (U) is `UNIT_CYC` clock cycles.

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset the control word, busy, done, bytes_read and every decoded field are all zero.
- R2: Mode 0 opens in two steps. First the control word is chip-select-bar only (bit 2) for one cycle. Then it is load (bit 0) plus program-enable-bar (bit 1), with chip-select-bar low, for 2U cycles before the first address.
- R3: Mode 1 opens with the control word at load only (bit 0) for 2U cycles. During a mode-1 read, bits 1 and 2 are never set.
- R4: For each byte the address field is rewritten and then held for 2U cycles. The field is bits 8:4 in mode 0 and bits 12:8 in mode 1. The strobe (bit 3) then rises and stays high for 2U cycles. The data byte is sampled on the last strobe-high cycle. The strobe then stays low for 2U cycles.
- R5: The address increments by one after each byte and wraps modulo 32. Each byte lands at shadow index equal to its fuse address, and shadow bytes outside the run keep their values.
- R6: After the last byte's low-strobe time, the word is held for another 2U cycles. Then mode 0 sets chip-select-bar, while mode 1 clears load. U cycles later, done is high for exactly one cycle with busy low.
- R7: A start with a length of zero produces done on the next cycle with bytes_read zero. The control word does not change and busy never rises.
- R8: Busy is high from the cycle after an accepted start until done. A start pulse while busy has no effect on the sequence, the mode or the length.
- R9: At done, bytes_read equals the requested length.
- R10: The version output is shadow byte 4 with bit 3 cleared. The process output is bits 3:0 of byte 6, and the revision output is bits 5:4 of byte 6.
- R11: Leakage select values 0, 1 and 2 return shadow bytes 23, 24 and 25. Select value 3 returns zero.
- R12: The temperature trim takes byte 31 as sign-magnitude (bit 7 sign, bits 6:0 magnitude) and outputs it in two's complement. A negative zero gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode | input | 1 | 0: chip-select variant, 1: load-only variant |
| start_addr | input | 5 | First fuse byte address |
| req_len | input | 6 | Number of bytes to read |
| fuse_dout | input | 8 | Data byte from the macro |
| leak_sel | input | 2 | Leakage channel select |
| fuse_ctrl | output | 16 | Control word to the macro |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| bytes_read | output | 6 | Bytes read by the last read |
| fuse_ver | output | 8 | Decoded version byte |
| proc_ver | output | 4 | Decoded process nibble |
| rev | output | 2 | Decoded revision |
| leak | output | 8 | Selected leakage byte |
| temp_trim | output | 8 | Signed temperature trim |

## Verification
The assertions assume that start is only meaningful while idle. They also assume that the mode input is allowed to change during a read, because the sequencer holds the mode it latched at the start. The bench keeps the fuse data at zero unless the strobe is high, so a byte captured outside the strobe window shows up as a wrong shadow value. Stimulus stays within a requested length of 32 or less and within the four leakage selects. A start pulse during a busy read deliberately carries a different mode and length, so that any leak of those values into the read becomes visible.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int CW        = 16;
  localparam int LOAD_B    = 0;
  localparam int PGENB_B   = 1;
  localparam int CSB_B     = 2;
  localparam int STB_B     = 3;
  localparam int ALSB_M0   = 4;
  localparam int ALSB_M1   = 8;
  localparam int VER_IDX   = 4;
  localparam int PROC_IDX  = 6;
  localparam int LEAK_BASE = 23;
  localparam int LEAK_N    = 3;
  localparam int TRIM_IDX  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_LDON, S_SETUP, S_ADDR, S_STB, S_GAP, S_TAIL, S_CLOSE
  } seq_st_e;

  // sign-magnitude byte to two's complement
  function automatic logic signed [7:0] sm_to_tc(input logic [7:0] v);
    logic signed [7:0] mag;
    mag = $signed({1'b0, v[6:0]});
    return v[7] ? -mag : mag;
  endfunction

  // version byte with its flag bit 3 removed
  function automatic logic [7:0] ver_clean(input logic [7:0] v);
    return v & 8'hF7;
  endfunction
endpackage

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= len - TW'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/fuse_rd_shadow.sv
module fuse_rd_shadow #(
  parameter int NB = 32,
  localparam int IW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic [7:0]      din,
  output logic [NB*8-1:0] bytes_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         b_q <= 8'h00;
      else if (we && idx == IW'(g))       b_q <= din;
    end
    assign bytes_o[g*8 +: 8] = b_q;
  end
endmodule

// File: rtl/fuse_rd_decode.sv
module fuse_rd_decode
  import fuse_rd_pkg::*;
#(
  parameter int NB = 32
) (
  input  logic [NB*8-1:0]   bytes_i,
  input  logic [1:0]        leak_sel,
  output logic [7:0]        fuse_ver,
  output logic [3:0]        proc_ver,
  output logic [1:0]        rev,
  output logic [7:0]        leak,
  output logic signed [7:0] temp_trim
);
  logic [7:0] b_ver, b_proc, b_trim;
  logic [7:0] leak_ch [LEAK_N];

  assign b_ver  = bytes_i[VER_IDX*8  +: 8];
  assign b_proc = bytes_i[PROC_IDX*8 +: 8];
  assign b_trim = bytes_i[TRIM_IDX*8 +: 8];

  for (genvar c = 0; c < LEAK_N; c++) begin : g_leak
    assign leak_ch[c] = bytes_i[(LEAK_BASE+c)*8 +: 8];
  end

  assign fuse_ver  = ver_clean(b_ver);
  assign proc_ver  = b_proc[3:0];
  assign rev       = b_proc[5:4];
  assign temp_trim = sm_to_tc(b_trim);

  always_comb begin
    leak = 8'h00;
    if (int'(leak_sel) < LEAK_N) leak = leak_ch[leak_sel];
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int UNIT_CYC = 4,
  parameter int NB       = 32,
  localparam int ADDR_W  = $clog2(NB),
  localparam int CNT_W   = $clog2(NB + 1),
  localparam int TW      = $clog2(2 * UNIT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  req_len,
  input  logic [7:0]        fuse_dout,
  input  logic [1:0]        leak_sel,
  output logic [CW-1:0]     fuse_ctrl,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  bytes_read,
  output logic [7:0]        fuse_ver,
  output logic [3:0]        proc_ver,
  output logic [1:0]        rev,
  output logic [7:0]        leak,
  output logic signed [7:0] temp_trim
);
  localparam logic [TW-1:0] ONE_U = TW'(UNIT_CYC);
  localparam logic [TW-1:0] TWO_U = TW'(2 * UNIT_CYC);

  seq_st_e           state;
  logic              mode_q, busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q, cnt_q;
  logic [CW-1:0]     word_q;
  logic              t_load, t_exp, sh_we;
  logic [TW-1:0]     t_len;
  logic [NB*8-1:0]   sh_bytes;

  // rewrite the mode-dependent address field of the control word
  function automatic logic [CW-1:0] put_addr(input logic [CW-1:0] w,
                                             input logic [ADDR_W-1:0] a,
                                             input logic m);
    logic [CW-1:0] r;
    r = w;
    for (int i = 0; i < ADDR_W; i++) begin
      if (m) r[ALSB_M1 + i] = a[i];
      else   r[ALSB_M0 + i] = a[i];
    end
    return r;
  endfunction

  // timer reload requests per state
  always_comb begin
    t_load = 1'b0;
    t_len  = TWO_U;
    sh_we  = 1'b0;
    unique case (state)
      S_IDLE:  t_load = start && (req_len != '0) && mode;
      S_LDON:  t_load = 1'b1;
      S_SETUP: t_load = t_exp;
      S_ADDR:  t_load = t_exp;
      S_STB:   begin t_load = t_exp; sh_we = t_exp; end
      S_GAP:   t_load = t_exp;
      S_TAIL:  begin t_load = t_exp; t_len = ONE_U; end
      S_CLOSE: t_load = 1'b0;
      default: t_load = 1'b0;
    endcase
  end

  fuse_rd_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expire(t_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          mode_q <= mode;
          addr_q <= start_addr;
          rem_q  <= req_len;
          cnt_q  <= '0;
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            if (mode) begin
              word_q <= CW'(1) << LOAD_B;
              state  <= S_SETUP;
            end else begin
              word_q <= CW'(1) << CSB_B;
              state  <= S_LDON;
            end
          end
        end
        S_LDON: begin
          word_q <= (CW'(1) << LOAD_B) | (CW'(1) << PGENB_B);
          state  <= S_SETUP;
        end
        S_SETUP: if (t_exp) begin
          word_q <= put_addr(word_q, addr_q, mode_q);
          state  <= S_ADDR;
        end
        S_ADDR: if (t_exp) begin
          word_q[STB_B] <= 1'b1;
          state         <= S_STB;
        end
        S_STB: if (t_exp) begin
          word_q[STB_B] <= 1'b0;
          cnt_q         <= cnt_q + CNT_W'(1);
          addr_q        <= addr_q + ADDR_W'(1);
          rem_q         <= rem_q - CNT_W'(1);
          state         <= S_GAP;
        end
        S_GAP: if (t_exp) begin
          if (rem_q != '0) begin
            word_q <= put_addr(word_q, addr_q, mode_q);
            state  <= S_ADDR;
          end else begin
            state  <= S_TAIL;
          end
        end
        S_TAIL: if (t_exp) begin
          if (mode_q) word_q[LOAD_B] <= 1'b0;
          else        word_q[CSB_B]  <= 1'b1;
          state <= S_CLOSE;
        end
        S_CLOSE: if (t_exp) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  fuse_rd_shadow #(.NB(NB)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(sh_we), .idx(addr_q), .din(fuse_dout),
    .bytes_o(sh_bytes)
  );

  fuse_rd_decode #(.NB(NB)) u_decode (
    .bytes_i(sh_bytes), .leak_sel(leak_sel), .fuse_ver(fuse_ver),
    .proc_ver(proc_ver), .rev(rev), .leak(leak), .temp_trim(temp_trim)
  );

  assign fuse_ctrl  = word_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign bytes_read = cnt_q;

  // strobe may only pulse while the macro is loaded
  assert_strobe_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[STB_B] |-> word_q[LOAD_B]);

  // a capture happens only on a strobe-high cycle whose timer has run out
  assert_capture_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sh_we |-> (word_q[STB_B] && t_exp));

  // load-only variant never touches chip-select-bar or program-enable-bar
  assert_mode1_pins_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_q) |-> (!word_q[CSB_B] && !word_q[PGENB_B]));

  // done is a single-cycle pulse and never coincides with busy
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // a start while busy leaves the latched mode and the run untouched
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && state != S_CLOSE) |=> (busy_q && $stable(mode_q)));
endmodule

// File: tb/tb_fuse_rd_seq.sv
module tb_fuse_rd_seq;
  localparam int U = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [4:0]  start_addr = '0;
  logic [5:0]  req_len = '0;
  logic [7:0]  fuse_dout;
  logic [1:0]  leak_sel = '0;
  logic [15:0] fuse_ctrl;
  logic        busy, done;
  logic [5:0]  bytes_read;
  logic [7:0]  fuse_ver, leak;
  logic [3:0]  proc_ver;
  logic [1:0]  rev;
  logic signed [7:0] temp_trim;

  always #10 clk = ~clk;   // 50 MHz

  fuse_rd_seq #(.UNIT_CYC(U)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .start_addr(start_addr), .req_len(req_len), .fuse_dout(fuse_dout),
    .leak_sel(leak_sel), .fuse_ctrl(fuse_ctrl), .busy(busy), .done(done),
    .bytes_read(bytes_read), .fuse_ver(fuse_ver), .proc_ver(proc_ver),
    .rev(rev), .leak(leak), .temp_trim(temp_trim)
  );

  // behavioural fuse array: data appears only while the strobe is high
  logic [7:0] fmem [32];
  logic       bm = 1'b0;
  assign fuse_dout = fuse_ctrl[3] ? fmem[bm ? fuse_ctrl[12:8] : fuse_ctrl[8:4]] : 8'h00;

  int         nvec = 0, nbad = 0;
  logic [7:0] sh [32];
  logic [15:0] cur = '0;
  logic [17:0] qv[$];
  string       qt[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(logic [15:0] w, bit b, bit d, int n, string t);
    repeat (n) begin qv.push_back({w, b, d}); qt.push_back(t); end
  endtask

  task automatic run_read(bit m, int a, int n, int poke);
    logic [15:0] w;
    int lsb, ad;
    lsb = m ? 8 : 4;
    if (n == 0) begin
      push(cur, 1'b0, 1'b1, 1, "R7");
      push(cur, 1'b0, 1'b0, 1, "R7");
    end else begin
      if (!m) begin
        push(16'h0004, 1'b1, 1'b0, 1, "R2");
        push(16'h0003, 1'b1, 1'b0, 2*U, "R2");
        w = 16'h0003;
      end else begin
        push(16'h0001, 1'b1, 1'b0, 2*U, "R3");
        w = 16'h0001;
      end
      for (int k = 0; k < n; k++) begin
        ad = (a + k) % 32;
        w = (w & ~(16'h001F << lsb)) | (16'(ad) << lsb);
        push(w, 1'b1, 1'b0, 2*U, "R4");
        push(w | 16'h0008, 1'b1, 1'b0, 2*U, "R4");
        push(w, 1'b1, 1'b0, (k == n-1) ? 4*U : 2*U, (k == n-1) ? "R6" : "R5");
        sh[ad] = fmem[ad];
      end
      w = m ? (w & ~16'h0001) : (w | 16'h0004);
      push(w, 1'b1, 1'b0, U, "R6");
      push(w, 1'b0, 1'b1, 1, "R6");
      push(w, 1'b0, 1'b0, 1, "R8");
      cur = w;
    end
    @(negedge clk);
    bm = m; mode = m; start_addr = 5'(a); req_len = 6'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; qv.size() > 0; i++) begin
      logic [17:0] e;
      string t;
      e = qv.pop_front(); t = qt.pop_front();
      chk(t, {fuse_ctrl, busy, done}, e);
      if (e[0]) chk("R9", bytes_read, n);
      if (i == poke) begin
        start = 1'b1; mode = ~m; req_len = 6'd7;   // R8: must be ignored
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic check_fields();
    logic [7:0] t;
    logic [7:0] lv [4];
    chk("R10 ver", fuse_ver, sh[4] & 8'hF7);
    chk("R10 proc", proc_ver, sh[6] % 16);
    chk("R10 rev", rev, (sh[6] / 16) % 4);
    t = sh[31];
    chk("R12 trim", 32'(temp_trim), t[7] ? 32'(-(int'(t) - 128)) : 32'(int'(t)));
    lv[0] = sh[23]; lv[1] = sh[24]; lv[2] = sh[25]; lv[3] = 8'h00;
    for (int c = 0; c < 4; c++) begin
      leak_sel = 2'(c);
      #1;
      chk("R11 leak", leak, lv[c]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin fmem[i] = 8'(i * 29 + 7); sh[i] = 8'h00; end
    fmem[4] = 8'h1F; fmem[6] = 8'hB5; fmem[31] = 8'h85;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", {fuse_ctrl, busy, done}, 18'h0);
    chk("R1 cnt", bytes_read, 0);
    chk("R1 ver", fuse_ver, 0);
    chk("R1 trim", 32'(temp_trim), 0);

    run_read(1'b0, 0, 32, 5);
    check_fields();                 // trim -5, version 0x17, proc 5, rev 3

    run_read(1'b1, 3, 0, -1);       // R7 zero length

    fmem[31] = 8'h05; fmem[0] = 8'h3C; fmem[23] = 8'hEE;
    run_read(1'b1, 30, 4, 8);       // R5 wrap 30,31,0,1; byte 23 kept
    check_fields();

    fmem[31] = 8'h80;
    run_read(1'b0, 31, 1, -1);      // R12 negative zero
    check_fields();

    fmem[23] = 8'hA1; fmem[24] = 8'hB2; fmem[25] = 8'hC3;
    run_read(1'b1, 23, 3, 2);
    check_fields();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule